// File: doc/BRIEF.md
# Interrupt and GPIO Register Block for a Power-Management Companion

This block is the byte-wide register file of a power-management companion device. A host reaches it through a byte-level serial-bus slave front end. The front end delivers three things: a pulse when a write transfer opens, a strobe with each received byte, and a strobe that asks for one byte of read data.

The block collects interrupt causes into a 16-bit status word. A 16-bit mask filters them onto a single active-high interrupt line, and software clears causes through two write-one-to-clear acknowledge addresses. A push-button input raises a status bit on its rising edge. Three general-purpose lines can be sampled as inputs or driven as outputs, but they never raise an interrupt.

Register access runs through a two-state machine, `BUS_DATA` and `BUS_ADDR`. It leaves reset in `BUS_DATA`. The transition *start seen* moves it from either state to `BUS_ADDR` when a write opens. The transition *address taken* moves it back to `BUS_DATA` on the next received byte, which is loaded into the register pointer. In `BUS_DATA` every received byte is written to the pointed register.

Register map (8-bit addresses):

| Address | Register |
|---|---|
| 0x00 | revision (reads 0x22) |
| 0x01 | device-off |
| 0x02 | mask bits 7:0 |
| 0x03 | mask bits 15:8 |
| 0x04 | status bits 7:0 |
| 0x05 | status bits 15:8 |
| 0x06 | acknowledge bits 7:0 |
| 0x07 | acknowledge bits 15:8 |
| 0x08 | GPIO direction |
| 0x09 | GPIO input view |
| 0x0A | GPIO output value |

All other addresses are unmapped.

Top module: `pmr_regblock`

## Requirements
- R1: After `wr_start`, the next received byte loads the 8-bit register pointer. Each later received byte is written to the pointed address, and the pointer then increments by one, wrapping from 0xFF to 0x00. A `wr_start` in the same cycle as `rx_valid` wins and the byte is dropped.
- R2: A `rd_req` (ignored when `rx_valid` or `wr_start` is high in the same cycle) loads `rd_data` with the byte at the pointer one cycle later, and the pointer then increments with the same 0xFF to 0x00 wrap.
- R3: `irq_out` is high exactly when some bit of status AND NOT mask is set. It follows any mask write, acknowledge or status change from the next clock edge on.
- R4: After reset the mask is 0x0FFF, the status is 0 and `irq_out` is low. Mask bits 7:0 are written and read at 0x02, bits 15:8 at 0x03.
- R5: A write to 0x06 clears the status bits 7:0 where the byte has ones. A write to 0x07 does the same for bits 15:8. Both addresses read 0x00.
- R6: A 0-to-1 change of `btn_in` sets status bit 11 (bit 3 of address 0x05) two clock edges later. A held high level or a falling edge sets nothing.
- R7: A direction write at 0x08 keeps only the bits under 0x67, and the reset value is 0x07. The output register at 0x0A keeps bits 2:0. `gpio_drv[i]` equals output bit i AND NOT direction bit i.
- R8: Address 0x09 reads the sampled `gpio_in` lines ORed with (NOT direction[2:0] AND output[2:0]). A change on `gpio_in` never alters status or `irq_out`.
- R9: Address 0x00 always reads 0x22 and ignores writes. Address 0x01 reads 0x00. Unmapped addresses read 0x00 and ignore writes.
- R10: Writing a byte with bit 0 set to 0x01 returns mask, status, direction and output to their reset values and sets the pointer to 0x00. The same write with bit 0 clear changes nothing.
- R11: When the push-button edge sets status bit 11 in the same cycle as an acknowledge of that bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Pulse: a write transfer opens |
| rx_valid | input | 1 | Pulse: received byte on `rx_data` |
| rx_data | input | 8 | Received byte |
| rd_req | input | 1 | Pulse: host requests one read byte |
| rd_data | output | 8 | Read byte, valid the cycle after `rd_req` |
| btn_in | input | 1 | Push-button level |
| gpio_in | input | 3 | General-purpose input lines |
| gpio_drv | output | 3 | General-purpose output drive |
| irq_out | output | 1 | Active-high interrupt request |

## Verification
A wrong pointer shows up on the first byte after a burst goes astray. A value lands at the wrong address, or a read returns a neighbour's contents, so every check reads back through the bus after the writes. A status or mask bit in the wrong state shows on `irq_out` one cycle after the write that caused it, and the bench compares the line against a model after every random mask and acknowledge update. Push-button and acknowledge collisions are lined up to the exact edge, so a lost priority shows as a cleared bit 11 on the next status read.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned STAT_W = 16;
    localparam int unsigned GPIO_N = 3;

    typedef enum logic [0:0] {
        BUS_DATA = 1'b0,
        BUS_ADDR = 1'b1
    } bus_state_t;

    localparam logic [BYTE_W-1:0] A_REV     = 8'h00;
    localparam logic [BYTE_W-1:0] A_OFF     = 8'h01;
    localparam logic [BYTE_W-1:0] A_MASK_LO = 8'h02;
    localparam logic [BYTE_W-1:0] A_MASK_HI = 8'h03;
    localparam logic [BYTE_W-1:0] A_STAT_LO = 8'h04;
    localparam logic [BYTE_W-1:0] A_STAT_HI = 8'h05;
    localparam logic [BYTE_W-1:0] A_ACK_LO  = 8'h06;
    localparam logic [BYTE_W-1:0] A_ACK_HI  = 8'h07;
    localparam logic [BYTE_W-1:0] A_DIR     = 8'h08;
    localparam logic [BYTE_W-1:0] A_GIN     = 8'h09;
    localparam logic [BYTE_W-1:0] A_GOUT    = 8'h0A;

endpackage

// File: rtl/pmr_bus_fsm.sv
module pmr_bus_fsm
    import pmr_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rd_req,
    input  logic              soft_rst,
    output logic              wr_en,
    output logic              rd_en,
    output logic [PTR_W-1:0]  cur_addr
);

    bus_state_t       state_q, state_d;
    logic [PTR_W-1:0] ptr_q;
    logic             ptr_load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_DATA;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and access strobes
    always_comb begin
        state_d  = state_q;
        wr_en    = 1'b0;
        ptr_load = 1'b0;
        unique case (state_q)
            BUS_DATA: begin
                if (wr_start) begin
                    state_d = BUS_ADDR;
                end else begin
                    wr_en = rx_valid;
                end
            end
            BUS_ADDR: begin
                if (wr_start) begin
                    state_d = BUS_ADDR;
                end else if (rx_valid) begin
                    ptr_load = 1'b1;
                    state_d  = BUS_DATA;
                end
            end
            default: state_d = BUS_DATA;
        endcase
        rd_en = rd_req && !rx_valid && !wr_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (soft_rst) begin
            ptr_q <= '0;
        end else if (ptr_load) begin
            ptr_q <= rx_data[PTR_W-1:0];
        end else if (wr_en || rd_en) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign cur_addr = ptr_q;

    // R1
    wr_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst) |=> (ptr_q == $past(ptr_q) + 1'b1));
    // R2
    rd_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (ptr_q == $past(ptr_q) + 1'b1));
    // R1
    addr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_ADDR && rx_valid && !wr_start) |=> (state_q == BUS_DATA));

endmodule

// File: rtl/pmr_irq_core.sv
module pmr_irq_core #(
    parameter int unsigned              STAT_W   = 16,
    parameter int unsigned              BYTE_W   = 8,
    parameter logic [STAT_W-1:0]        MASK_RST = 16'h0FFF,
    parameter int unsigned              BTN_BIT  = 11,
    localparam int unsigned             NBYTES   = STAT_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [NBYTES-1:0] mask_we,
    input  logic [NBYTES-1:0] ack_we,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              btn_in,
    output logic [STAT_W-1:0] mask_q,
    output logic [STAT_W-1:0] status_q,
    output logic              irq
);

    logic              btn_s, btn_q, btn_rise;
    logic [STAT_W-1:0] clr_vec, hw_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            btn_s <= 1'b0;
            btn_q <= 1'b0;
        end else begin
            btn_s <= btn_in;
            btn_q <= btn_s;
        end
    end

    assign btn_rise = btn_s & ~btn_q;

    always_comb begin
        hw_set          = '0;
        hw_set[BTN_BIT] = btn_rise;
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[b*BYTE_W +: BYTE_W] <= MASK_RST[b*BYTE_W +: BYTE_W];
            end else if (soft_rst) begin
                mask_q[b*BYTE_W +: BYTE_W] <= MASK_RST[b*BYTE_W +: BYTE_W];
            end else if (mask_we[b]) begin
                mask_q[b*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
        assign clr_vec[b*BYTE_W +: BYTE_W] = ack_we[b] ? wr_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (soft_rst) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_vec) | hw_set;
        end
    end

    assign irq = |(status_q & ~mask_q);

    // R6
    btn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_rise && !soft_rst) |=> status_q[BTN_BIT]);
    // R5
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ack_we) && !soft_rst) |=> ((status_q & $past(clr_vec) & ~$past(hw_set)) == '0));
    // R10
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mask_q == MASK_RST && status_q == '0));
    // R8
    no_other_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status_q & ~$past(status_q)) & ~(STAT_W'(1) << BTN_BIT)) == '0));

endmodule

// File: rtl/pmr_gpio_regs.sv
module pmr_gpio_regs #(
    parameter int unsigned       GPIO_N   = 3,
    parameter int unsigned       BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] DIR_KEEP = 8'h67,
    parameter logic [BYTE_W-1:0] DIR_RST  = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              dir_we,
    input  logic              out_we,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [GPIO_N-1:0] pin_in,
    output logic [BYTE_W-1:0] dir_q,
    output logic [GPIO_N-1:0] out_q,
    output logic [GPIO_N-1:0] in_q,
    output logic [GPIO_N-1:0] drive
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= DIR_RST;
            out_q <= '0;
        end else if (soft_rst) begin
            dir_q <= DIR_RST;
            out_q <= '0;
        end else begin
            if (dir_we) dir_q <= wr_data & DIR_KEEP;
            if (out_we) out_q <= wr_data[GPIO_N-1:0];
        end
    end

    for (genvar i = 0; i < GPIO_N; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_q[i] <= 1'b0;
            end else begin
                in_q[i] <= pin_in[i];
            end
        end
        assign drive[i] = out_q[i] & ~dir_q[i];
    end

    // R7
    dir_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_we && !soft_rst) |=> ((dir_q & ~DIR_KEEP) == '0));
    // R7
    out_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && !soft_rst) |=> (out_q == $past(wr_data[GPIO_N-1:0])));

endmodule

// File: rtl/pmr_regblock.sv
module pmr_regblock
    import pmr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] REV_ID   = 8'h22,
    parameter logic [STAT_W-1:0] MASK_RST = 16'h0FFF,
    parameter int unsigned       BTN_BIT  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rd_req,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              btn_in,
    input  logic [GPIO_N-1:0] gpio_in,
    output logic [GPIO_N-1:0] gpio_drv,
    output logic              irq_out
);

    localparam int unsigned NBYTES = STAT_W / BYTE_W;

    logic              wr_en, rd_en, soft_rst;
    logic [BYTE_W-1:0] cur_addr, rd_mux;
    logic [NBYTES-1:0] mask_we, ack_we;
    logic [STAT_W-1:0] mask_q, status_q;
    logic [BYTE_W-1:0] dir_q;
    logic [GPIO_N-1:0] out_q, in_q, gin_view;

    pmr_bus_fsm #(.DATA_W(BYTE_W), .PTR_W(BYTE_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_start (wr_start),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rd_req   (rd_req),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .cur_addr (cur_addr)
    );

    assign soft_rst   = wr_en && (cur_addr == A_OFF) && rx_data[0];
    assign mask_we[0] = wr_en && (cur_addr == A_MASK_LO);
    assign mask_we[1] = wr_en && (cur_addr == A_MASK_HI);
    assign ack_we[0]  = wr_en && (cur_addr == A_ACK_LO);
    assign ack_we[1]  = wr_en && (cur_addr == A_ACK_HI);

    pmr_irq_core #(
        .STAT_W   (STAT_W),
        .BYTE_W   (BYTE_W),
        .MASK_RST (MASK_RST),
        .BTN_BIT  (BTN_BIT)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .mask_we  (mask_we),
        .ack_we   (ack_we),
        .wr_data  (rx_data),
        .btn_in   (btn_in),
        .mask_q   (mask_q),
        .status_q (status_q),
        .irq      (irq_out)
    );

    pmr_gpio_regs #(.GPIO_N(GPIO_N), .BYTE_W(BYTE_W)) u_gpio (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .dir_we   (wr_en && (cur_addr == A_DIR)),
        .out_we   (wr_en && (cur_addr == A_GOUT)),
        .wr_data  (rx_data),
        .pin_in   (gpio_in),
        .dir_q    (dir_q),
        .out_q    (out_q),
        .in_q     (in_q),
        .drive    (gpio_drv)
    );

    assign gin_view = in_q | (~dir_q[GPIO_N-1:0] & out_q);

    always_comb begin
        case (cur_addr)
            A_REV:     rd_mux = REV_ID;
            A_MASK_LO: rd_mux = mask_q[7:0];
            A_MASK_HI: rd_mux = mask_q[15:8];
            A_STAT_LO: rd_mux = status_q[7:0];
            A_STAT_HI: rd_mux = status_q[15:8];
            A_DIR:     rd_mux = dir_q;
            A_GIN:     rd_mux = {{(BYTE_W-GPIO_N){1'b0}}, gin_view};
            A_GOUT:    rd_mux = {{(BYTE_W-GPIO_N){1'b0}}, out_q};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end

    // R9
    rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cur_addr == A_REV) |=> (rd_data == REV_ID));
    // R5
    ack_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (cur_addr == A_ACK_LO || cur_addr == A_ACK_HI)) |=> (rd_data == '0));

endmodule

// File: tb/pmr_regblock_tb.sv
`timescale 1ns/1ps
module pmr_regblock_tb;

    localparam logic [7:0] T_REV = 8'h00, T_OFF = 8'h01, T_MLO = 8'h02, T_MHI = 8'h03;
    localparam logic [7:0] T_SLO = 8'h04, T_SHI = 8'h05, T_ALO = 8'h06, T_AHI = 8'h07;
    localparam logic [7:0] T_DIR = 8'h08, T_GIN = 8'h09, T_GOUT = 8'h0A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_start = 1'b0, rx_valid = 1'b0, rd_req = 1'b0, btn_in = 1'b0;
    logic [7:0] rx_data = '0;
    logic [2:0] gpio_in = '0;
    logic [7:0] rd_data;
    logic [2:0] gpio_drv;
    logic       irq_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [15:0] m_mask, m_status;
    logic [7:0]  m_dir;
    logic [2:0]  m_out;

    always #2 clk = ~clk;

    pmr_regblock u_dut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .rx_valid(rx_valid),
        .rx_data(rx_data), .rd_req(rd_req), .rd_data(rd_data), .btn_in(btn_in),
        .gpio_in(gpio_in), .gpio_drv(gpio_drv), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mask = 16'h0FFF; m_status = '0; m_dir = 8'h07; m_out = '0;
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        case (a)
            T_OFF:  if (d[0]) model_reset();
            T_MLO:  m_mask[7:0]  = d;
            T_MHI:  m_mask[15:8] = d;
            T_ALO:  m_status[7:0]  = m_status[7:0]  & ~d;
            T_AHI:  m_status[15:8] = m_status[15:8] & ~d;
            T_DIR:  m_dir = d & 8'h67;
            T_GOUT: m_out = d[2:0];
            default: ;
        endcase
    endtask

    function automatic logic exp_irq();
        return |(m_status & ~m_mask);
    endfunction

    task automatic pulse_start();
        wr_start = 1'b1; @(negedge clk); wr_start = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b; @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0; v = rd_data;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d);
        pulse_start(); send(a); send(d); model_write(a, d);
    endtask

    task automatic rreg(input logic [7:0] a, output logic [7:0] v);
        pulse_start(); send(a); rd(v);
    endtask

    task automatic btn_pulse();
        btn_in = 1'b1; repeat (3) @(negedge clk);
        m_status[11] = 1'b1;
        btn_in = 1'b0; repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [31:0] r, a;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 reset state
        chk("R4 irq after reset", irq_out, 1'b0);
        rreg(T_MLO, v); chk("R4 mask lo reset", v, 8'hFF);
        rreg(T_MHI, v); chk("R4 mask hi reset", v, 8'h0F);
        rreg(T_SHI, v); chk("R4 status hi reset", v, 8'h00);
        rreg(T_DIR, v); chk("R7 dir reset", v, 8'h07);
        rreg(T_REV, v); chk("R9 revision", v, 8'h22);

        // R2 burst read with auto-increment
        pulse_start(); send(T_REV);
        rd(v); chk("R2 burst rev", v, 8'h22);
        rd(v); chk("R9 off reads zero", v, 8'h00);
        rd(v); chk("R2 burst mask lo", v, 8'hFF);
        rd(v); chk("R2 burst mask hi", v, 8'h0F);

        // R1 write burst wrapping past 0xFF; R9 writes to rev/unmapped ignored
        pulse_start(); send(8'hFE); send(8'h11); send(8'h22); send(8'h33);
        send(8'h00); send(8'hA5);
        model_write(T_MLO, 8'hA5);
        rreg(T_MLO, v); chk("R1 wrap write mask lo", v, 8'hA5);
        rreg(T_REV, v); chk("R9 rev ignores write", v, 8'h22);
        rreg(T_MHI, v); chk("R10 off bit0 clear no reset", v, 8'h0F);

        // R2 read wrap; R9 unmapped read
        pulse_start(); send(8'hFF);
        rd(v); chk("R9 unmapped reads zero", v, 8'h00);
        rd(v); chk("R2 read wrap to rev", v, 8'h22);
        rd(v); chk("R2 read wrap off", v, 8'h00);
        rd(v); chk("R2 read wrap mask lo", v, 8'hA5);

        // R6 button edge, R3 mask gating, R5 ack
        btn_pulse();
        rreg(T_SHI, v); chk("R6 rise sets bit 11", v, 8'h08);
        chk("R3 masked no irq", irq_out, 1'b0);
        wreg(T_MHI, 8'h07);
        chk("R3 unmasked irq", irq_out, 1'b1);
        btn_in = 1'b1; repeat (3) @(negedge clk);
        m_status[11] = 1'b1;
        wreg(T_AHI, 8'h08);
        repeat (4) @(negedge clk);
        rreg(T_SHI, v); chk("R6 held level sets nothing", v, 8'h00);
        chk("R5 ack drops irq", irq_out, 1'b0);
        btn_in = 1'b0; repeat (4) @(negedge clk);
        rreg(T_SHI, v); chk("R6 fall sets nothing", v, 8'h00);
        rreg(T_ALO, v); chk("R5 ack lo reads zero", v, 8'h00);
        rreg(T_AHI, v); chk("R5 ack hi reads zero", v, 8'h00);

        // R11 hardware set beats same-cycle acknowledge
        pulse_start(); send(T_AHI);
        btn_in = 1'b1; @(negedge clk);
        send(8'h08);
        m_status[11] = 1'b1;
        rreg(T_SHI, v); chk("R11 set wins over ack", v, 8'h08);
        chk("R3 irq after collision", irq_out, exp_irq());
        btn_in = 1'b0;
        wreg(T_AHI, 8'hFF);
        repeat (2) @(negedge clk);

        // R7 / R8 GPIO
        wreg(T_DIR, 8'hFF);
        rreg(T_DIR, v); chk("R7 dir keep bits", v, 8'h67);
        wreg(T_GOUT, 8'hFF);
        rreg(T_GOUT, v); chk("R7 out keeps 2:0", v, 8'h07);
        chk("R7 drive off when input dir", gpio_drv, 3'b000);
        wreg(T_DIR, 8'h00);
        chk("R7 drive when output dir", gpio_drv, 3'b111);
        rreg(T_GIN, v); chk("R8 gin shows outputs", v, 8'h07);
        wreg(T_DIR, 8'h07);
        gpio_in = 3'b101; repeat (3) @(negedge clk);
        rreg(T_GIN, v); chk("R8 gin sampled lines", v, 8'h05);
        rreg(T_SLO, v); chk("R8 gpio no status lo", v, 8'h00);
        rreg(T_SHI, v); chk("R8 gpio no status hi", v, 8'h00);
        chk("R8 gpio no irq", irq_out, exp_irq());
        wreg(T_DIR, 8'h05);
        gpio_in = 3'b000; repeat (3) @(negedge clk);
        rreg(T_GIN, v); chk("R8 gin mixed", v, {5'b0, 3'b000 | (~m_dir[2:0] & m_out)});

        // random mask / button / acknowledge mix
        for (int i = 0; i < 40; i++) begin
            r = $urandom; a = $urandom;
            pulse_start(); send(T_MLO); send(r[7:0]); send(r[15:8]);
            model_write(T_MLO, r[7:0]); model_write(T_MHI, r[15:8]);
            chk("R3 irq after mask burst", irq_out, exp_irq());
            if (r[16]) btn_pulse();
            chk("R3 irq after button", irq_out, exp_irq());
            wreg(r[17] ? T_AHI : T_ALO, a[7:0]);
            chk("R5 irq after ack", irq_out, exp_irq());
            rreg(T_SHI, v); chk("R5 status hi model", v, m_status[15:8]);
        end

        // R10 soft reset and pointer return to 0x00
        wreg(T_MHI, 8'h5A); wreg(T_DIR, 8'h00); wreg(T_GOUT, 8'h03); btn_pulse();
        pulse_start(); send(T_OFF); send(8'h01);
        model_reset();
        send(8'h77); send(8'h00); send(8'h3C);
        model_write(T_MLO, 8'h3C);
        rreg(T_MLO, v); chk("R10 pointer to zero after reset", v, 8'h3C);
        rreg(T_MHI, v); chk("R10 mask hi default", v, 8'h0F);
        rreg(T_DIR, v); chk("R10 dir default", v, 8'h07);
        rreg(T_GOUT, v); chk("R10 out default", v, 8'h00);
        rreg(T_SHI, v); chk("R10 status cleared", v, 8'h00);
        chk("R10 irq low", irq_out, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule